// File: doc/BRIEF.md
# Digit-Serial Binary Field Multiplier

This block multiplies two elements of the binary field GF(2^M) held in polynomial basis and returns the product reduced modulo a fixed irreducible polynomial. The reduction polynomial is x^M plus a lower part given as the parameter `RPOLY`, where bit j of `RPOLY` is the coefficient of x^j. The multiplication is digit-serial. Operand B is cut into S = ceil(M/G) slices of G bits each. In each busy cycle, one slice is multiplied by the whole of operand A. That product is added to the running sum after the sum has been multiplied by x^G, and the total is reduced, all within the cycle.

The digit width G trades area for latency. With G = M the product is ready after one busy cycle. With G = 1 the block works as a bit-serial multiplier taking M busy cycles. Any value in between gives S busy cycles.

A caller raises `start_i` for one cycle while the block is idle, with both operands on the inputs. It then waits for the one-cycle `done_o` pulse and reads `result_o`, which holds its value until the next accepted start.

Top module: `gfds_mul`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `busy_o` is 0, `done_o` is 0 and `result_o` is all zeros.
- R2: A `start_i` sampled high while `busy_o` is low captures `a_i` and `b_i` at that clock edge and raises `busy_o` from the next cycle. Later changes on `a_i` and `b_i` do not affect that operation.
- R3: After an accepted start, `busy_o` stays high for exactly S = ceil(M/G) cycles. `done_o` is high for exactly one cycle, the cycle in which `busy_o` first reads low again, and `done_o` is never high together with `busy_o`.
- R4: While `done_o` is high, `result_o` equals A·B mod (x^M + RPOLY), where A and B are the captured operands and bit j of each vector is the coefficient of x^j.
- R5: B is consumed in G-bit slices, most significant slice first. When M is not a multiple of G, the top slice is padded with zeros on its high side, and the product is still exact.
- R6: A `start_i` sampled high while `busy_o` is high is ignored. The operation in flight keeps its operands, its length and its result.
- R7: While idle, `result_o` keeps the last product (or zero after reset) until the next accepted start.
- R8: A start sampled on the same edge that ends an operation (the cycle where `done_o` is high) is accepted.
- R9: With G = M, `done_o` rises two cycles after the cycle in which start is driven. With G = 1, it rises M + 1 cycles after that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication (accepted only while idle) |
| a_i | input | M | Operand A, bit j is the coefficient of x^j |
| b_i | input | M | Operand B, bit j is the coefficient of x^j |
| busy_o | output | 1 | High while a multiplication is in progress |
| done_o | output | 1 | One-cycle pulse when the result becomes valid |
| result_o | output | M | Product A·B mod the reduction polynomial |

## Verification
The assertions check the following on every cycle:
- `done_o` lasts a single cycle and only ends a busy period.
- The step counter stays in range.
- A start seen while busy leaves the captured A untouched.
- The result is frozen while idle with no start.

Only the bench's scenarios can show that the numeric product is correct. The bench checks it against a schoolbook multiply-then-divide model for three digit widths (1, 3 and M), including a width that does not divide M. The scenarios also cover the exact S-cycle latency for each width, overlapping start pulses that one instance rejects while another accepts, and starts issued on the done cycle.

// File: rtl/gfds_pkg.sv
package gfds_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } gfds_phase_e;

    function automatic int gfds_ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/gfds_digit_step.sv
// One iteration: z_o = (z_i * x^G + dig_i * a_i) mod R, evaluated in one cycle
// as a chain of G multiply-by-x-and-conditionally-add stages, MSB of the digit first.
module gfds_digit_step #(
    parameter int          M     = 8,
    parameter int          G     = 3,
    parameter logic [M-1:0] RPOLY = 8'h1B
) (
    input  logic [M-1:0] z_i,
    input  logic [M-1:0] a_i,
    input  logic [G-1:0] dig_i,
    output logic [M-1:0] z_o
);

    logic [M-1:0] chain [G+1];

    assign chain[0] = z_i;

    for (genvar j = 0; j < G; j++) begin : g_stage
        logic [M-1:0] shifted;
        logic [M-1:0] reduced;
        assign shifted      = {chain[j][M-2:0], 1'b0};
        assign reduced      = shifted ^ (chain[j][M-1] ? RPOLY : '0);
        assign chain[j+1]   = reduced ^ (dig_i[G-1-j] ? a_i : '0);
    end

    assign z_o = chain[G];

endmodule

// File: rtl/gfds_seq.sv
// Sequencer: accepts a start while idle, counts S steps, pulses done.
module gfds_seq
    import gfds_pkg::*;
#(
    parameter int S = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = (S > 1) ? $clog2(S) : 1;

    typedef struct packed {
        gfds_phase_e   phase;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       accept_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept_d  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    accept_d   = 1'b1;
                    st_d.phase = PH_RUN;
                    st_d.cnt   = CW'(S - 1);
                end
            end
            PH_RUN: begin
                if (st_q.cnt == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o = accept_d;
    assign busy_o   = (st_q.phase == PH_RUN);
    assign done_o   = st_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o) && !busy_o); // R3

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (st_q.cnt <= CW'(S - 1))); // R3

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.cnt != '0) |=> busy_o); // R6

endmodule

// File: rtl/gfds_mul.sv
module gfds_mul
    import gfds_pkg::*;
#(
    parameter int           M     = 8,
    parameter int           G     = 3,
    parameter logic [M-1:0] RPOLY = 8'h1B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [M-1:0] result_o
);

    localparam int S = gfds_ceil_div(M, G);
    localparam int W = S * G;

    typedef struct packed {
        logic [M-1:0] a;
        logic [W-1:0] bsh;
        logic [M-1:0] z;
    } dp_state_t;

    dp_state_t    dp_d, dp_q;
    logic         accept;
    logic [G-1:0] digit;
    logic [M-1:0] z_step;

    gfds_seq #(.S(S)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    assign digit = dp_q.bsh[W-1 -: G];

    gfds_digit_step #(.M(M), .G(G), .RPOLY(RPOLY)) step_i (
        .z_i   (dp_q.z),
        .a_i   (dp_q.a),
        .dig_i (digit),
        .z_o   (z_step)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.a   = a_i;
            dp_d.bsh = W'(b_i);
            dp_d.z   = '0;
        end else if (busy_o) begin
            dp_d.z   = z_step;
            dp_d.bsh = dp_q.bsh << G;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign result_o = dp_q.z;

    AST_BUSY_KEEPS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(dp_q.a)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o)); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3

endmodule

// File: tb/gfds_mul_tb_top.sv
module gfds_mul_tb_top;

    localparam int          M     = 8;
    localparam logic [M-1:0] RPOLY = 8'h1B;
    localparam int          NI    = 3;
    localparam int          GV [NI] = '{3, 1, 8};
    localparam int          WD    = 50000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [M-1:0] a_i = '0;
    logic [M-1:0] b_i = '0;
    logic         busy [NI];
    logic         done [NI];
    logic [M-1:0] res  [NI];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // model state
    logic         mb [NI];
    logic         md [NI];
    logic [M-1:0] mr [NI];
    logic [M-1:0] mp [NI];
    int           mc [NI];

    always #4 clk = ~clk;

    gfds_mul #(.M(M), .G(GV[0]), .RPOLY(RPOLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy[0]), .done_o(done[0]), .result_o(res[0]));
    gfds_mul #(.M(M), .G(GV[1]), .RPOLY(RPOLY)) dut_g1_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy[1]), .done_o(done[1]), .result_o(res[1]));
    gfds_mul #(.M(M), .G(GV[2]), .RPOLY(RPOLY)) dut_gm_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
        .busy_o(busy[2]), .done_o(done[2]), .result_o(res[2]));

    // schoolbook product then polynomial long division
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [2*M-1:0] prod = '0;
        logic [2*M-1:0] poly = {{(M-1){1'b0}}, 1'b1, RPOLY};
        for (int i = 0; i < M; i++)
            if (b[i]) prod ^= ({{M{1'b0}}, a} << i);
        for (int i = 2*M-2; i >= M; i--)
            if (prod[i]) prod ^= (poly << (i - M));
        return prod[M-1:0];
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // cycle model
    always @(posedge clk) begin
        for (int k = 0; k < NI; k++) begin
            if (!rst_n) begin
                mb[k] = 1'b0; md[k] = 1'b0; mr[k] = '0; mc[k] = 0;
            end else begin
                md[k] = 1'b0;
                if (mb[k]) begin
                    mc[k]--;
                    if (mc[k] == 0) begin
                        mb[k] = 1'b0; md[k] = 1'b1; mr[k] = mp[k];
                    end
                end else if (start_i) begin
                    mb[k] = 1'b1;
                    mc[k] = (M + GV[k] - 1) / GV[k];
                    mp[k] = ref_mul(a_i, b_i);
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NI; k++) begin
                chk(busy[k] == mb[k], $sformatf("R2 R3 busy inst%0d", k), 32'(busy[k]), 32'(mb[k]));
                chk(done[k] == md[k], $sformatf("R3 R9 done inst%0d", k), 32'(done[k]), 32'(md[k]));
                if (!mb[k])
                    chk(res[k] == mr[k], $sformatf("R4 R5 R7 result inst%0d", k), 32'(res[k]), 32'(mr[k]));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD) begin
            fails++;
            $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, WD);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_idle();
        do begin
            @(negedge clk);
            a_i = M'($urandom);   // R2: inputs wander while busy
            b_i = M'($urandom);
        end while (mb[0] || mb[1] || mb[2]);
    endtask

    task automatic op(input logic [M-1:0] a, input logic [M-1:0] b);
        @(negedge clk);
        start_i = 1'b1; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        a_i = M'($urandom); b_i = M'($urandom);
        wait_idle();
    endtask

    initial begin
        int lat1, latm, c;
        void'($urandom(32'h5eed));
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk(busy[k] == 1'b0, "R1 busy in reset", 32'(busy[k]), 0);
            chk(done[k] == 1'b0, "R1 done in reset", 32'(done[k]), 0);
            chk(res[k] == '0,   "R1 result in reset", 32'(res[k]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NI; k++)
            chk(!busy[k] && res[k] == '0, "R1 after reset", 32'(res[k]), 0);

        // R4 known vector
        op(8'h57, 8'h83);
        for (int k = 0; k < NI; k++)
            chk(res[k] == 8'hC1, "R4 known product", 32'(res[k]), 32'hC1);

        // R5 top slice with padding, edge operands
        op(8'h00, 8'hA5);
        op(8'hFF, 8'hFF);
        op(8'h01, 8'h80);
        chk(res[0] == 8'h80, "R5 padded top slice", 32'(res[0]), 32'h80);
        op(8'h80, 8'h80);

        // R6: start while busy on the G=1 instance
        @(negedge clk);
        start_i = 1'b1; a_i = 8'h12; b_i = 8'h34;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        start_i = 1'b1; a_i = 8'h9A; b_i = 8'hBC;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(res[1] == ref_mul(8'h12, 8'h34), "R6 busy start ignored", 32'(res[1]), 32'(ref_mul(8'h12, 8'h34)));

        // R8: start held high, accepted on done cycles
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            start_i = 1'b1; a_i = M'($urandom); b_i = M'($urandom);
            @(negedge clk);
        end
        start_i = 1'b0;
        wait_idle();

        // R9: latency for G=1 and G=M
        @(negedge clk);
        start_i = 1'b1; a_i = 8'h3C; b_i = 8'hC3;
        lat1 = 0; latm = 0; c = 0;
        @(negedge clk);
        start_i = 1'b0;
        c = 1;
        while ((lat1 == 0 || latm == 0) && c < 40) begin
            @(negedge clk);
            c++;
            if (done[1] && lat1 == 0) lat1 = c;
            if (done[2] && latm == 0) latm = c;
        end
        chk(lat1 == M + 1, "R9 G=1 latency", 32'(lat1), 32'(M + 1));
        chk(latm == 2, "R9 G=M latency", 32'(latm), 2);
        wait_idle();

        // R7: idle hold while inputs move
        repeat (6) begin
            @(negedge clk);
            a_i = M'($urandom); b_i = M'($urandom);
        end

        // random operations
        for (int i = 0; i < 40; i++)
            op(M'($urandom), M'($urandom));

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule